// File: doc/BRIEF.md
# Burst-Capable External Bus Slave

This block is the slave side of a shared, strobe-driven external bus. It holds a small array of data words and answers read and write strobes from a bus master. A plain access uses the address on the bus. In a sequential burst the master drives the address only once. After that the slave produces each following address from its own counter, which steps by one after every completed word and wraps at the end of the array.

The slave can stretch any access by holding the acknowledge line low for a programmable number of cycles, from 0 to 7. A transfer completes only in a cycle where acknowledge is high and exactly one strobe is active. The master keeps its strobe asserted until that cycle, then releases it. If both strobes are active together, the request is refused and an error line is raised.

Top module: `burst_bus_slave`

## Requirements
- R1: After reset every word reads as zero, acknowledge is high, the error line is low, read data is zero and no burst is open.
- R2: When the burst line is low and no burst is open, the access uses `addr_i`.
- R3: When `burst_i` is high in a transfer, the word address is one more than the address of the previously completed transfer, and `addr_i` is ignored.
- R4: A transfer with a strobe active and the burst line low, while a burst is open, still uses the counter address. It closes the burst, so the next access samples `addr_i` again.
- R5: The address counter wraps modulo the array depth of 16 words, so that address 15 is followed by address 0.
- R6: With a wait count of N on `wait_cfg_i`, acknowledge stays low for the first N cycles of a strobe and rises in cycle N+1.
- R7: While acknowledge is low, no word is written and the address counter does not advance. A strobe that is withdrawn before acknowledge rises has no effect.
- R8: A completed write stores `wdata_i` at the selected word. While `rd_i` alone is active, `rdata_o` shows the selected word; otherwise `rdata_o` is zero.
- R9: When `rd_i` and `wr_i` are both high, `err_o` is high and acknowledge is high. Nothing is written, and the counter and burst state are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| burst_i | input | 1 | Sequential burst indicator |
| addr_i | input | 4 | Word address from the master |
| wdata_i | input | 16 | Write data |
| wait_cfg_i | input | 3 | Wait cycles inserted per transfer |
| rdata_o | output | 16 | Read data |
| ack_o | output | 1 | Acknowledge; low inserts a wait state |
| err_o | output | 1 | Both strobes active together |

## Verification
The stimulus covers single writes and reads, and a write burst and a read burst in which `addr_i` carries junk values after the first word. A slave that follows the bus address during a burst therefore returns the wrong word. The last word of each burst is placed so that using `addr_i` on it gives a different result from using the counter. The access that follows then shows whether the address is sampled fresh again. A burst that starts at the top word checks the wrap. Wait counts from 0 to 4 are used and the number of low-acknowledge cycles is counted, which separates an off-by-one wait from a correct one. Strobes withdrawn during a wait, and clashing strobes, are followed by reads that show whether anything was written or whether the counter moved.

// File: rtl/bslv_pkg.sv
package bslv_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_CLASH = 2'd3
  } acc_e;

  function automatic acc_e acc_decode(input logic rd, input logic wr);
    acc_e k;
    unique case ({wr, rd})
      2'b01:   k = ACC_READ;
      2'b10:   k = ACC_WRITE;
      2'b11:   k = ACC_CLASH;
      default: k = ACC_IDLE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/bslv_addr_gen.sv
module bslv_addr_gen #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              burst_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic              in_burst_o
);
  logic [ADDR_W-1:0] cnt_q;
  logic              in_burst_q;

  // counter drives the address on burst cycles and on the closing cycle
  assign eff_addr_o = (burst_i || in_burst_q) ? cnt_q : addr_i;
  assign in_burst_o = in_burst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      in_burst_q <= 1'b0;
    end else if (done_i) begin
      cnt_q      <= eff_addr_o + 1'b1; // wraps at 2**ADDR_W
      in_burst_q <= burst_i;
    end
  end

  // R3
  burst_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && burst_i) |=> in_burst_q);
  // R4
  burst_closes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !burst_i) |=> !in_burst_q);
endmodule

// File: rtl/bslv_wait_gen.sv
module bslv_wait_gen #(
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              access_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  output logic              ack_o
);
  logic [WAIT_W-1:0] wcnt_q;

  assign ack_o = !access_i || (wcnt_q >= wait_cfg_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wcnt_q <= '0;
    else if (access_i && !ack_o) wcnt_q <= wcnt_q + 1'b1;
    else                        wcnt_q <= '0;
  end

  // R6
  wait_counts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_i && !ack_o) |=> (wcnt_q != '0));
endmodule

// File: rtl/bslv_regfile.sv
module bslv_regfile #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                mem_q[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g))      mem_q[g] <= wdata_i;
    end
  end

  assign rdata_o = re_i ? mem_q[addr_i] : '0;
endmodule

// File: rtl/burst_bus_slave.sv
module burst_bus_slave
  import bslv_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              burst_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WAIT_W-1:0] wait_cfg_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  output logic              err_o
);
  acc_e              kind;
  logic              access;
  logic              done;
  logic [ADDR_W-1:0] eff_addr;
  logic              in_burst;

  assign kind   = acc_decode(rd_i, wr_i);
  assign access = (kind == ACC_READ) || (kind == ACC_WRITE);
  assign done   = access && ack_o;
  assign err_o  = (kind == ACC_CLASH);

  bslv_wait_gen #(.WAIT_W(WAIT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .access_i   (access),
    .wait_cfg_i (wait_cfg_i),
    .ack_o      (ack_o)
  );

  bslv_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .burst_i    (burst_i),
    .addr_i     (addr_i),
    .eff_addr_o (eff_addr),
    .in_burst_o (in_burst)
  );

  bslv_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (done && kind == ACC_WRITE),
    .re_i    (kind == ACC_READ),
    .addr_i  (eff_addr),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o)
  );

  // R7
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack_o && (burst_i || in_burst) && $stable(burst_i)) |=> $stable(eff_addr));
  // R9
  clash_inert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i) |=> $stable(in_burst));
  // R9
  clash_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && wr_i) |-> (ack_o && err_o));
endmodule

// File: tb/burst_bus_slave_tb.sv
module burst_bus_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd = 1'b0, wr = 1'b0, burst = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [2:0]  wcfg = '0;
  logic [15:0] rdata;
  logic        ack, err;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  burst_bus_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .wr_i(wr), .burst_i(burst),
    .addr_i(addr), .wdata_i(wdata), .wait_cfg_i(wcfg),
    .rdata_o(rdata), .ack_o(ack), .err_o(err)
  );

  // {rd, wr, burst, addr, wdata, wait, expected rdata}
  localparam logic [41:0] VEC [12] = '{
    {1'b0,1'b1,1'b0,4'd3, 16'hA003,3'd0,16'h0000}, // single write, R2
    {1'b0,1'b1,1'b0,4'd5, 16'h1111,3'd1,16'h0000}, // burst head
    {1'b0,1'b1,1'b1,4'd15,16'h2222,3'd2,16'h0000}, // -> 6, R3
    {1'b0,1'b1,1'b1,4'd0, 16'h3333,3'd0,16'h0000}, // -> 7
    {1'b0,1'b1,1'b0,4'd9, 16'h4444,3'd3,16'h0000}, // last -> 8, R4
    {1'b1,1'b0,1'b0,4'd6, 16'h0000,3'd0,16'h2222},
    {1'b1,1'b0,1'b0,4'd8, 16'h0000,3'd0,16'h4444}, // R4
    {1'b1,1'b0,1'b0,4'd9, 16'h0000,3'd1,16'h0000}, // R4
    {1'b1,1'b0,1'b0,4'd5, 16'h0000,3'd1,16'h1111},
    {1'b1,1'b0,1'b1,4'd0, 16'h0000,3'd0,16'h2222}, // R3
    {1'b1,1'b0,1'b0,4'd0, 16'h0000,3'd2,16'h3333}, // R4 closing read
    {1'b1,1'b0,1'b0,4'd3, 16'h0000,3'd4,16'hA003}  // R4 fresh sample
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; burst = 1'b0;
  endtask

  // complete transfer, checking wait cycles and read data
  task automatic xfer(input logic r, input logic w, input logic b, input logic [3:0] a,
                      input logic [15:0] d, input logic [2:0] wc, input logic [15:0] exp);
    int n;
    @(negedge clk);
    rd = r; wr = w; burst = b; addr = a; wdata = d; wcfg = wc;
    n = 0;
    #1;
    while (!ack && n < 20) begin
      @(negedge clk); #1; n++;
    end
    check("R6 wait cycles", n, wc);
    if (r) check("R8 read data", rdata, exp);
    idle();
  endtask

  // strobe withdrawn after k low-ack cycles
  task automatic abort(input logic r, input logic w, input logic b, input logic [3:0] a,
                       input logic [15:0] d, input logic [2:0] wc, input int k);
    @(negedge clk);
    rd = r; wr = w; burst = b; addr = a; wdata = d; wcfg = wc;
    for (int i = 0; i < k; i++) begin
      #1; check("R7 ack low during wait", ack, 1'b0);
      @(negedge clk);
    end
    rd = 1'b0; wr = 1'b0; burst = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    check("R1 ack", ack, 1'b1);
    check("R1 err", err, 1'b0);
    check("R1 rdata", rdata, 16'h0);
    rst_n = 1'b1;
    xfer(1'b1, 1'b0, 1'b0, 4'd12, 16'h0, 3'd0, 16'h0000); // R1 word cleared

    for (int i = 0; i < 12; i++) begin
      logic [41:0] v;
      v = VEC[i];
      xfer(v[41], v[40], v[39], v[38:35], v[34:19], v[18:16], v[15:0]);
    end

    // R5 wrap: head at 15, burst word -> 0, closing word -> 1
    xfer(1'b0, 1'b1, 1'b0, 4'd15, 16'h5555, 3'd0, 16'h0);
    xfer(1'b0, 1'b1, 1'b1, 4'd7,  16'h6666, 3'd1, 16'h0);
    xfer(1'b0, 1'b1, 1'b0, 4'd7,  16'h7777, 3'd0, 16'h0);
    xfer(1'b1, 1'b0, 1'b0, 4'd0,  16'h0, 3'd0, 16'h6666); // R5
    xfer(1'b1, 1'b0, 1'b0, 4'd1,  16'h0, 3'd0, 16'h7777); // R5
    xfer(1'b1, 1'b0, 1'b0, 4'd15, 16'h0, 3'd0, 16'h5555); // R5
    xfer(1'b1, 1'b0, 1'b0, 4'd7,  16'h0, 3'd0, 16'h3333); // R5 word 7 untouched

    // R7 withdrawn single write has no effect
    abort(1'b0, 1'b1, 1'b0, 4'd11, 16'hDEAD, 3'd4, 2);
    xfer(1'b1, 1'b0, 1'b0, 4'd11, 16'h0, 3'd0, 16'h0000); // R7

    // R7 counter holds across a withdrawn burst write
    xfer(1'b0, 1'b1, 1'b0, 4'd13, 16'hABCD, 3'd0, 16'h0);
    xfer(1'b1, 1'b0, 1'b0, 4'd12, 16'h0, 3'd0, 16'h0000); // head, counter -> 13
    abort(1'b0, 1'b1, 1'b1, 4'd2, 16'hBAD0, 3'd3, 1);
    xfer(1'b1, 1'b0, 1'b1, 4'd2, 16'h0, 3'd0, 16'hABCD);  // R7 still 13
    xfer(1'b1, 1'b0, 1'b0, 4'd2, 16'h0, 3'd0, 16'h0000);  // closes at 14

    // R9 clashing strobes
    @(negedge clk);
    rd = 1'b1; wr = 1'b1; burst = 1'b0; addr = 4'd2; wdata = 16'hBEEF; wcfg = 3'd2;
    #1;
    check("R9 err", err, 1'b1);
    check("R9 ack", ack, 1'b1);
    idle();
    #1; check("R9 err drops", err, 1'b0);
    xfer(1'b1, 1'b0, 1'b0, 4'd2, 16'h0, 3'd0, 16'h0000); // R9 nothing written

    // R8 rdata zero when no read strobe
    @(negedge clk); addr = 4'd13; #1;
    check("R8 rdata idle", rdata, 16'h0);

    summary();
    $finish;
  end
endmodule